// File: doc/BRIEF.md
# Switched Unit-Weight Glitch Monitor

This block watches a stream of N-bit converter input codes. It accepts one code on each clock cycle in which the valid strobe is high. Each accepted code is turned into the switch-control word of the coding scheme in use, and that word is compared with the word of the previous accepted code. The block reports how many unit analog weights changed state between the two codes. This number serves as a first-order measure of the glitch that the transition would cause in the converter output.

Two coding schemes are available, chosen by a static configuration input. The first is plain binary. The second is segmented coding, in which the top `SEG_W` bits of the code drive a bank of thermometer lines and the remaining low bits stay binary. In segmented coding each thermometer line switches `2^(DATA_W-SEG_W)` unit weights, and binary bit j switches `2^j` unit weights. Alongside the per-transition count, the block keeps the largest count seen since reset. A synchronous clear input zeroes this peak value.

Top module: `glitch_mon`

## Requirements
- R1: After reset, the first code accepted with `valid_i` high only loads the history register: one cycle later `cnt_vld_o` is 0.
- R2: Every later accepted code produces its count on `cnt_o`, with `cnt_vld_o` high, exactly one clock cycle after the code is presented.
- R3: In a cycle with `valid_i` low, the code is ignored: one cycle later `cnt_vld_o` is 0, `cnt_o` keeps its value, and the history register is not updated. The next count is taken against the last accepted code.
- R4: With `seg_en_i` = 0 (binary), the count is the sum of 2^j over every bit position j in which the new and the previous code differ. For example, the mid-scale step from 2^(N-1)-1 to 2^(N-1) reports 2^N-1.
- R5: With `seg_en_i` = 1 (segmented), the top `SEG_W` code bits, taken as a value h, drive 2^SEG_W-1 thermometer lines. Line k is on when h > k, and each line that toggles adds 2^(N-SEG_W). The low N-SEG_W bits add 2^j for each bit j that differs.
- R6: In segmented mode, `SEG_W` = 2 makes the mid-scale step report 2^(N-1)-1, `SEG_W` = N makes the count equal the absolute difference of the two codes, and no count ever exceeds 2^N-1.
- R7: `peak_o` holds the largest count reported since reset or since the last clear. It never decreases except through a clear.
- R8: `clear_i` high sets `peak_o` to 0 at the next clock edge. It takes priority over a count produced in the same cycle, and that count still appears on `cnt_o`.
- R9: While `rst_ni` is low, `cnt_vld_o`, `cnt_o` and `peak_o` are 0, and the history is marked empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_en_i | input | 1 | Static coding select: 0 binary, 1 segmented |
| valid_i | input | 1 | Code strobe |
| code_i | input | DATA_W | Converter input code |
| clear_i | input | 1 | Synchronous clear of the peak register |
| cnt_vld_o | output | 1 | Count on `cnt_o` is new this cycle |
| cnt_o | output | DATA_W | Switched unit weights for the last transition |
| peak_o | output | DATA_W | Largest count since reset or clear |

## Verification
The bench builds three copies of the block with `DATA_W` = 8 and drives them with one shared stream. The first copy uses `SEG_W` = 3, a split where the thermometer and binary parts both contribute to most counts. The second uses `SEG_W` = 2, which gives the mid-scale value 127 that R6 names. The third uses `SEG_W` = 8, which gives a purely thermometer-coded path with 255 lines and no binary part, so the count reduces to the absolute code difference. Toggling `seg_en_i` on the same copies also checks the binary path and its full-scale value of 255.

// File: rtl/gm_pkg.sv
package gm_pkg;
  typedef enum logic {
    MODE_BIN = 1'b0,
    MODE_SEG = 1'b1
  } gm_mode_e;
endpackage

// File: rtl/therm_enc.sv
module therm_enc #(
  parameter int IN_W  = 3,
  localparam int LINES = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  code_i,
  output logic [LINES-1:0] therm_o
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign therm_o[k] = (code_i > IN_W'(k));
  end
endmodule

// File: rtl/seg_weight.sv
module seg_weight #(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 3
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] prev_i,
  output logic [DATA_W-1:0] cnt_o
);
  localparam int LO_W  = DATA_W - SEG_W;
  localparam int LINES = (1 << SEG_W) - 1;

  logic [LINES-1:0] th_cur, th_prev;
  logic [SEG_W:0]   lines_sw;

  therm_enc #(.IN_W(SEG_W)) u_th_cur (
    .code_i (cur_i[DATA_W-1:LO_W]),
    .therm_o(th_cur)
  );
  therm_enc #(.IN_W(SEG_W)) u_th_prev (
    .code_i (prev_i[DATA_W-1:LO_W]),
    .therm_o(th_prev)
  );

  assign lines_sw = (SEG_W+1)'($countones(th_cur ^ th_prev));

  // each thermometer line carries 2^LO_W unit weights
  if (LO_W > 0) begin : g_mixed
    logic [LO_W-1:0] lo_x;
    assign lo_x  = cur_i[LO_W-1:0] ^ prev_i[LO_W-1:0];
    assign cnt_o = (DATA_W'(lines_sw) << LO_W) | DATA_W'(lo_x);
  end else begin : g_therm
    assign cnt_o = DATA_W'(lines_sw);
  end
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         upd_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] peak_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      peak_o <= '0;
    else if (clear_i)                 peak_o <= '0;
    else if (upd_i && val_i > peak_o) peak_o <= val_i;
  end
endmodule

// File: rtl/glitch_mon.sv
module glitch_mon #(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_en_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              clear_i,
  output logic              cnt_vld_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] peak_o
);
  import gm_pkg::*;

  gm_mode_e          mode;
  logic [DATA_W-1:0] prev_q;
  logic              have_q;
  logic [DATA_W-1:0] seg_cnt, bin_cnt, cnt_d;
  logic              upd;

  assign mode    = gm_mode_e'(seg_en_i);
  assign bin_cnt = code_i ^ prev_q;  // binary bit j weighs 2^j
  assign upd     = valid_i & have_q;

  seg_weight #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_seg (
    .cur_i (code_i),
    .prev_i(prev_q),
    .cnt_o (seg_cnt)
  );

  assign cnt_d = (mode == MODE_SEG) ? seg_cnt : bin_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      have_q    <= 1'b0;
      cnt_o     <= '0;
      cnt_vld_o <= 1'b0;
    end else begin
      cnt_vld_o <= upd;
      if (valid_i) begin
        prev_q <= code_i;
        have_q <= 1'b1;
      end
      if (upd) cnt_o <= cnt_d;
    end
  end

  peak_hold #(.W(DATA_W)) u_peak (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .upd_i  (upd),
    .val_i  (cnt_d),
    .peak_o (peak_o)
  );
endmodule

// File: rtl/glitch_mon_chk.sv
module glitch_mon_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         clear_i,
  input logic         cnt_vld_o,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] peak_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (valid_i) seen_q <= 1'b1;
  end

  // R1
  first_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !seen_q |=> !cnt_vld_o);
  // R2
  cnt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && seen_q |=> cnt_vld_o);
  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !cnt_vld_o && $stable(cnt_o));
  // R7
  peak_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> peak_o >= $past(peak_o));
  // R7
  peak_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_vld_o && !$past(clear_i) |-> peak_o >= cnt_o);
  // R8
  peak_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> peak_o == '0);
endmodule

bind glitch_mon glitch_mon_chk #(.W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .clear_i  (clear_i),
  .cnt_vld_o(cnt_vld_o),
  .cnt_o    (cnt_o),
  .peak_o   (peak_o)
);

// File: tb/sim_glitch_mon.sv
module sim_glitch_mon;
  localparam int CLK_P = 10;
  localparam int NV    = 12;

  // stimulus: coding select, code; expected counts for SEG_W = 3, 2, 8
  localparam logic       V_SEG  [NV] = '{1,1,1,0,0,1,1,1,0,0,1,1};
  localparam logic [7:0] V_CODE [NV] = '{8'h00,8'h7F,8'h80,8'h7F,8'h80,8'hFF,
                                         8'h00,8'h00,8'h05,8'h0A,8'h3C,8'h5C};
  localparam int E3 [NV] = '{0,127, 63,255,255,127,255,0,5,15,54,32};
  localparam int E2 [NV] = '{0,127,127,255,255,127,255,0,5,15,54,96};
  localparam int E8 [NV] = '{0,127,  1,255,255,127,255,0,5,15,50,32};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seg_en = 1'b0, vld = 1'b0, clr = 1'b0;
  logic [7:0] code = '0;
  logic       v0, v1, v2;
  logic [7:0] c0, c1, c2, p0, p1, p2;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  glitch_mon #(.DATA_W(8), .SEG_W(3)) u0 (.clk_i(clk), .rst_ni(rst_n), .seg_en_i(seg_en),
    .valid_i(vld), .code_i(code), .clear_i(clr), .cnt_vld_o(v0), .cnt_o(c0), .peak_o(p0));
  glitch_mon #(.DATA_W(8), .SEG_W(2)) u1 (.clk_i(clk), .rst_ni(rst_n), .seg_en_i(seg_en),
    .valid_i(vld), .code_i(code), .clear_i(clr), .cnt_vld_o(v1), .cnt_o(c1), .peak_o(p1));
  glitch_mon #(.DATA_W(8), .SEG_W(8)) u2 (.clk_i(clk), .rst_ni(rst_n), .seg_en_i(seg_en),
    .valid_i(vld), .code_i(code), .clear_i(clr), .cnt_vld_o(v2), .cnt_o(c2), .peak_o(p2));

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(input logic s, input logic v, input logic [7:0] c, input logic cl);
    seg_en = s; vld = v; code = c; clr = cl;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 vld", int'(v0), 0); chk("R9 cnt", int'(c0), 0); chk("R9 peak", int'(p0), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(V_SEG[i], 1'b1, V_CODE[i], 1'b0);
      if (i == 0) begin
        chk("R1 first load", int'(v0), 0);
      end else begin
        chk("R2 vld", int'(v0), 1);
        chk(V_SEG[i] ? "R5 seg3" : "R4 bin", int'(c0), E3[i]);
        chk(V_SEG[i] ? "R6 seg2" : "R4 bin seg2", int'(c1), E2[i]);
        chk(V_SEG[i] ? "R6 seg8" : "R4 bin seg8", int'(c2), E8[i]);
      end
    end
    chk("R7 peak", int'(p0), 255);
    // R3: ignored code, then count against last accepted 0x5C
    step(1'b1, 1'b0, 8'hFF, 1'b0);
    chk("R3 idle vld", int'(v0), 0);
    chk("R3 idle cnt held", int'(c0), 32);
    step(1'b1, 1'b1, 8'h5D, 1'b0);
    chk("R3 history kept", int'(c0), 1);
    // R8 clear alone
    step(1'b1, 1'b0, 8'h00, 1'b1);
    chk("R8 clear", int'(p0), 0);
    step(1'b1, 1'b1, 8'h5C, 1'b0);
    chk("R7 peak after clear", int'(p0), 1);
    // R8 clear wins over same-cycle count
    step(1'b1, 1'b1, 8'h00, 1'b1);
    chk("R8 cnt kept", int'(c0), 92);
    chk("R8 clear priority", int'(p0), 0);
    step(1'b1, 1'b1, 8'h01, 1'b0);
    chk("R7 peak", int'(p0), 1);
    step(1'b1, 1'b1, 8'h21, 1'b0);
    chk("R5 one line", int'(c0), 32);
    chk("R7 peak rise", int'(p0), 32);
    step(1'b1, 1'b1, 8'h20, 1'b0);
    chk("R7 peak held", int'(p0), 32);
    chk("R7 small cnt", int'(c0), 1);
    // R9 reset mid-run, then R1 again
    vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 vld", int'(v0), 0); chk("R9 peak", int'(p0), 0); chk("R9 cnt", int'(c0), 0);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 8'hAA, 1'b0);
    chk("R1 reload", int'(v0), 0);
    step(1'b0, 1'b1, 8'h55, 1'b0);
    chk("R4 alt bits", int'(c0), 255);
    chk("R6 bound", int'(c2 <= 8'd255), 1);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule